// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is a single DMA channel that streams bytes between system memory and one peripheral picked from up to sixteen. It owns two buffer slots. Each slot holds a start address and a byte count. While the channel drains one slot, software refills the other, so a long stream runs without gaps. The transfer direction is fixed when the block is built: memory to peripheral, or peripheral to memory.

The channel runs a four-state engine: idle, stall, on and next. Software reads the state back from a status register. The engine raises a next-buffer event when it moves from a finished slot to a waiting one. It sits in stall when it runs dry. A peripheral error raises its own flag, and the channel can either halt on that flag or carry on. One interrupt line combines the three flags with their enables. To shut the channel down, software first waits for stall and then clears the enable.

Top module: `pdma_pp_channel`

## Requirements
- R1: After reset every register reads zero, the state field reads idle, `irq` is low, and neither `mem_req` nor `per_ack` is asserted.
- R2: Register map, by byte offset of `reg_addr`:
  - 0x00 control: bit0 stall-irq enable, bit1 next-buffer-irq enable, bit3 error-irq enable, bit4 channel enable, bit6 ignore errors. The other bits read 0.
  - 0x04 flags: bit0 stall, bit1 next-buffer, bit3 error.
  - 0x08 port select: bits [3:0], driven on `port_sel`.
  - 0x0C status: state in bits [5:4].
  - Slot 0: count at 0x20, base at 0x24. Slot 1: count at 0x30, base at 0x34.
  - Counts are 16 bits wide and base addresses 32 bits wide; all of these read back as written.
- R3: Writing a slot's count register marks that slot loaded. With enable set, an idle or stalled channel takes a loaded slot and goes to on. The status encoding is idle=0, stall=1, on=2, next=3. Next means the other slot is loaded while one is active.
- R4: A slot with base B and count N moves exactly N bytes, one per memory access, at addresses B, B+1, …, B+N-1 in that order. A count of 0 moves nothing.
- R5: When the active slot ends and the other slot is not loaded, the channel enters stall. Flag bit0 reads 1 exactly while the state is stall.
- R6: When the active slot ends and the other slot is loaded, the channel switches to it without a stall and sets next-buffer flag bit1. Any count-register write clears bit1.
- R7: When restarting from stall or idle, the channel prefers the slot after the one that last ended; it takes the other slot only if the preferred one is not loaded.
- R8: Clearing enable sends a stalled channel to idle. An on or next channel finishes the byte in flight, goes to idle and drops both loaded marks; no bytes move after that.
- R9: A peripheral error during a byte sets flag bit3. With ignore clear, no new byte starts until a write to the flags register clears bit3. With ignore set, the transfer continues.
- R10: `irq` is high exactly when some flag bit (0, 1 or 3) is set together with the matching control enable bit.
- R11: A byte moves only after `per_req` is seen high, and `per_ack` is a one-cycle strobe per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |
| port_sel | output | 4 | Selected peripheral |
| per_req | input | 1 | Peripheral ready for a byte |
| per_ack | output | 1 | Byte transfer strobe to peripheral |
| per_wdata | output | 8 | Byte to peripheral |
| per_rdata | input | 8 | Byte from peripheral |
| per_err | input | 1 | Peripheral error, sampled with per_ack |
| irq | output | 1 | Combined interrupt |

## Verification
The main function is driven with a sweep of slot-count pairs, including zero counts. Depending on how the counts fall against the register writes, the channel either hands over straight to slot 1 or restarts from stall; in both cases the byte stream must match the address pattern. A held-off peripheral lets the next state be seen before any byte moves. A stop-and-reload sequence tells the preferred-slot order apart from plain slot order. Error cases inject a fault on a chosen byte, with ignore clear and with ignore set, which separates the halt behaviour from the continue behaviour. A mid-stream enable drop shows that the loaded marks are discarded.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_STALL = 2'd1,
    CH_ON    = 2'd2,
    CH_NEXT  = 2'd3
  } ch_state_e;

  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_MEM  = 2'd1,
    MV_PER  = 2'd2
  } mv_state_e;

  localparam int BYTE_W = 8;

  localparam logic [5:0] OFS_CTRL = 6'h00;
  localparam logic [5:0] OFS_FLAG = 6'h04;
  localparam logic [5:0] OFS_PORT = 6'h08;
  localparam logic [5:0] OFS_STAT = 6'h0C;

  localparam int B_STALL = 0;
  localparam int B_NFB   = 1;
  localparam int B_ERR   = 3;
  localparam int B_EN    = 4;
  localparam int B_IGN   = 6;

  localparam logic [7:0] CTRL_MASK = 8'h5B;
  localparam logic [7:0] FLAG_MASK = 8'h0B;

  function automatic logic [5:0] cnt_ofs(input int slot);
    return 6'h20 + 6'(slot * 16);
  endfunction

  function automatic logic [5:0] base_ofs(input int slot);
    return 6'h24 + 6'(slot * 16);
  endfunction

  function automatic logic pick_slot(input logic [1:0] loaded, input logic pref);
    return loaded[pref] ? pref : ~pref;
  endfunction

  function automatic ch_state_e run_state(input logic other_loaded);
    return other_loaded ? CH_NEXT : CH_ON;
  endfunction

  function automatic logic irq_of(input logic [7:0] flags, input logic [7:0] ctrl);
    return |(flags & ctrl & FLAG_MASK);
  endfunction

endpackage

// File: rtl/pdma_regs.sv
module pdma_regs import pdma_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSEL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [5:0]             addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  input  ch_state_e              state,
  input  logic [7:0]             flags,
  output logic [7:0]             ctrl,
  output logic [PSEL_W-1:0]      psel,
  output logic [1:0][ADDR_W-1:0] base,
  output logic [1:0][CNT_W-1:0]  cnt,
  output logic [1:0]             cnt_wr,
  output logic                   flag_clr
);

  logic [7:0]             ctrl_q;
  logic [PSEL_W-1:0]      psel_q;
  logic [1:0][ADDR_W-1:0] base_q;
  logic [1:0][CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      psel_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (we) begin
      if (addr == OFS_CTRL) ctrl_q <= wdata[7:0] & CTRL_MASK;
      if (addr == OFS_PORT) psel_q <= wdata[PSEL_W-1:0];
      for (int s = 0; s < 2; s++) begin
        if (addr == cnt_ofs(s))  cnt_q[s]  <= wdata[CNT_W-1:0];
        if (addr == base_ofs(s)) base_q[s] <= wdata[ADDR_W-1:0];
      end
    end
  end

  always_comb begin
    for (int s = 0; s < 2; s++) cnt_wr[s] = we && (addr == cnt_ofs(s));
  end

  assign flag_clr = we && (addr == OFS_FLAG);

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_CTRL:    rdata = 32'(ctrl_q);
      OFS_FLAG:    rdata = 32'(flags);
      OFS_PORT:    rdata = 32'(psel_q);
      OFS_STAT:    rdata = {26'd0, state, 4'd0};
      cnt_ofs(0):  rdata = 32'(cnt_q[0]);
      base_ofs(0): rdata = 32'(base_q[0]);
      cnt_ofs(1):  rdata = 32'(cnt_q[1]);
      base_ofs(1): rdata = 32'(base_q[1]);
      default:     rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign psel = psel_q;
  assign base = base_q;
  assign cnt  = cnt_q;

endmodule

// File: rtl/pdma_mover.sv
module pdma_mover import pdma_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter bit MEM_TO_PER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              per_req,
  output logic              per_ack,
  output logic [BYTE_W-1:0] per_wdata,
  input  logic [BYTE_W-1:0] per_rdata,
  input  logic              per_err,
  output logic              byte_done,
  output logic              err_evt,
  output logic              idle
);

  mv_state_e         xs_q;
  logic [BYTE_W-1:0] hold_q;

  assign mem_addr = addr;
  assign idle     = (xs_q == MV_IDLE);

  generate
    if (MEM_TO_PER) begin : g_tx
      logic unused_prd;
      assign unused_prd = ^per_rdata;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          xs_q   <= MV_IDLE;
          hold_q <= '0;
        end else begin
          unique case (xs_q)
            MV_IDLE: if (go && per_req) xs_q <= MV_MEM;
            MV_MEM: if (mem_ack) begin
              hold_q <= mem_rdata;
              xs_q   <= MV_PER;
            end
            default: xs_q <= MV_IDLE;
          endcase
        end
      end

      always_comb begin
        mem_req   = (xs_q == MV_MEM);
        mem_we    = 1'b0;
        mem_wdata = '0;
        per_ack   = (xs_q == MV_PER);
        per_wdata = hold_q;
        byte_done = per_ack;
        err_evt   = per_ack && per_err;
      end
    end else begin : g_rx
      logic unused_mrd;
      assign unused_mrd = ^mem_rdata;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          xs_q   <= MV_IDLE;
          hold_q <= '0;
        end else begin
          unique case (xs_q)
            MV_IDLE: if (go && per_req) xs_q <= MV_PER;
            MV_PER: begin
              hold_q <= per_rdata;
              xs_q   <= MV_MEM;
            end
            default: if (mem_ack) xs_q <= MV_IDLE;
          endcase
        end
      end

      always_comb begin
        per_ack   = (xs_q == MV_PER);
        per_wdata = '0;
        err_evt   = per_ack && per_err;
        mem_req   = (xs_q == MV_MEM);
        mem_we    = 1'b1;
        mem_wdata = hold_q;
        byte_done = mem_req && mem_ack;
      end
    end
  endgenerate

  // R11: the strobe towards the peripheral never lasts two cycles
  a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> !per_ack);

  // R11: an idle mover without a peripheral request stays idle
  a_r11_need_req: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !per_req) |=> idle);

endmodule

// File: rtl/pdma_seq.sv
module pdma_seq import pdma_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   ign,
  input  logic [1:0]             cnt_wr,
  input  logic                   flag_clr,
  input  logic [1:0][ADDR_W-1:0] base,
  input  logic [1:0][CNT_W-1:0]  cnt,
  input  logic                   byte_done,
  input  logic                   err_evt,
  input  logic                   mover_idle,
  output ch_state_e              state,
  output logic [ADDR_W-1:0]      addr,
  output logic                   go,
  output logic [7:0]             flags
);

  ch_state_e         state_q, n_state;
  logic              cur_q, n_cur, nxt_q, n_nxt;
  logic [1:0]        loaded_q, n_loaded;
  logic [ADDR_W-1:0] addr_q, n_addr;
  logic [CNT_W-1:0]  rem_q, n_rem;
  logic              nfb_q, n_nfb, err_q, n_err;
  logic              take, take_s, ev_switch, running, halted;

  assign running = (state_q == CH_ON) || (state_q == CH_NEXT);
  assign halted  = err_q && !ign;

  always_comb begin
    n_state   = state_q;
    n_cur     = cur_q;
    n_nxt     = nxt_q;
    n_loaded  = loaded_q;
    n_addr    = addr_q;
    n_rem     = rem_q;
    n_nfb     = nfb_q;
    n_err     = err_q;
    take      = 1'b0;
    take_s    = cur_q;
    ev_switch = 1'b0;
    if (!running) begin
      if (!en) begin
        n_state = CH_IDLE;
      end else if (|loaded_q) begin
        take    = 1'b1;
        take_s  = pick_slot(loaded_q, nxt_q);
        n_state = CH_ON;
      end
    end else begin
      if (!en && mover_idle) begin
        n_state  = CH_IDLE;
        n_loaded = '0;
        n_nxt    = 1'b0;
      end else if (byte_done) begin
        n_addr = addr_q + ADDR_W'(1);
        n_rem  = rem_q - CNT_W'(1);
      end else if (en && mover_idle && rem_q == '0) begin
        if (loaded_q[~cur_q]) begin
          take      = 1'b1;
          take_s    = ~cur_q;
          ev_switch = 1'b1;
        end else begin
          n_state = CH_STALL;
          n_nxt   = ~cur_q;
        end
      end
    end
    if (take) begin
      n_cur            = take_s;
      n_addr           = base[take_s];
      n_rem            = cnt[take_s];
      n_loaded[take_s] = 1'b0;
    end
    n_loaded = n_loaded | cnt_wr;
    if (n_state == CH_ON || n_state == CH_NEXT) n_state = run_state(n_loaded[~n_cur]);
    if (|cnt_wr)   n_nfb = 1'b0;
    if (ev_switch) n_nfb = 1'b1;
    if (flag_clr)  n_err = 1'b0;
    if (err_evt)   n_err = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CH_IDLE;
      cur_q    <= 1'b0;
      nxt_q    <= 1'b0;
      loaded_q <= '0;
      addr_q   <= '0;
      rem_q    <= '0;
      nfb_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= n_state;
      cur_q    <= n_cur;
      nxt_q    <= n_nxt;
      loaded_q <= n_loaded;
      addr_q   <= n_addr;
      rem_q    <= n_rem;
      nfb_q    <= n_nfb;
      err_q    <= n_err;
    end
  end

  assign go    = running && en && (rem_q != '0) && !halted;
  assign state = state_q;
  assign addr  = addr_q;

  always_comb begin
    flags          = '0;
    flags[B_STALL] = (state_q == CH_STALL);
    flags[B_NFB]   = nfb_q;
    flags[B_ERR]   = err_q;
  end

  // R4: a completed byte always has a remaining count behind it
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (rem_q != '0));

  // R5: stall is only reached with the active slot drained
  a_r5_stall_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_STALL) |-> (rem_q == '0));

  // R6: a fresh next-buffer flag comes with a running channel
  a_r6_switch_running: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nfb_q) |-> running);

  // R9: a halted, idle mover does not start a byte
  a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && mover_idle) |=> mover_idle);

endmodule

// File: rtl/pdma_pp_channel.sv
module pdma_pp_channel import pdma_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int PSEL_W     = 4,
  parameter bit MEM_TO_PER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  output logic [PSEL_W-1:0] port_sel,
  input  logic              per_req,
  output logic              per_ack,
  output logic [7:0]        per_wdata,
  input  logic [7:0]        per_rdata,
  input  logic              per_err,
  output logic              irq
);

  ch_state_e              chan_state;
  logic [7:0]             flags, ctrl;
  logic [1:0][ADDR_W-1:0] base;
  logic [1:0][CNT_W-1:0]  cnt;
  logic [1:0]             cnt_wr;
  logic                   flag_clr, go, byte_done, err_evt, mover_idle;
  logic [ADDR_W-1:0]      cur_addr;

  pdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PSEL_W(PSEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .state(chan_state), .flags(flags), .ctrl(ctrl),
    .psel(port_sel), .base(base), .cnt(cnt), .cnt_wr(cnt_wr), .flag_clr(flag_clr)
  );

  pdma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(ctrl[B_EN]), .ign(ctrl[B_IGN]),
    .cnt_wr(cnt_wr), .flag_clr(flag_clr), .base(base), .cnt(cnt),
    .byte_done(byte_done), .err_evt(err_evt), .mover_idle(mover_idle),
    .state(chan_state), .addr(cur_addr), .go(go), .flags(flags)
  );

  pdma_mover #(.ADDR_W(ADDR_W), .MEM_TO_PER(MEM_TO_PER)) u_mover (
    .clk(clk), .rst_n(rst_n), .go(go), .addr(cur_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .per_req(per_req), .per_ack(per_ack), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .per_err(per_err),
    .byte_done(byte_done), .err_evt(err_evt), .idle(mover_idle)
  );

  assign irq = irq_of(flags, ctrl);

  // R8: an idle channel touches neither memory nor peripheral
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_state == CH_IDLE) |-> (!mem_req && !per_ack));

  // R10: the interrupt line always has a pending flag behind it
  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != 8'd0));

endmodule

// File: tb/pdma_pp_channel_test.sv
module pdma_pp_channel_test;

  localparam logic [5:0] A_CTRL = 6'h00, A_FLAG = 6'h04, A_PORT = 6'h08, A_STAT = 6'h0C;
  localparam logic [5:0] A_CNT0 = 6'h20, A_BASE0 = 6'h24, A_CNT1 = 6'h30, A_BASE1 = 6'h34;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, mem_ack, per_ack, irq;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, per_wdata;
  logic [3:0]  port_sel;
  logic        per_req = 1'b1, per_err = 1'b0;

  int nchk = 0, nerr = 0, ncap = 0, nexp = 0, err_idx = 999;
  logic [7:0]  cap  [64];
  logic [31:0] expa [64];

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mem_ack   = mem_req;
  assign mem_rdata = pat(mem_addr);

  pdma_pp_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .port_sel(port_sel),
    .per_req(per_req), .per_ack(per_ack), .per_wdata(per_wdata),
    .per_rdata(8'h00), .per_err(per_err), .irq(irq)
  );

  always @(negedge clk) begin
    per_err = 1'b0;
    if (rst_n && per_ack) begin
      per_err = (ncap == err_idx);
      if (ncap < 64) cap[ncap] = per_wdata;
      ncap++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; per_req = 1'b1; err_idx = 999; ncap = 0; nexp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic add_exp(input logic [31:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      expa[nexp] = b + 32'(i);
      nexp++;
    end
  endtask

  task automatic chk_stream(input string tag);
    chk({tag, " byte count"}, 32'(ncap), 32'(nexp));
    for (int i = 0; i < nexp && i < ncap && i < 64; i++)
      chk({tag, " byte data"}, 32'(cap[i]), 32'(pat(expa[i])));
  endtask

  task automatic wait_stall();
    logic [31:0] v;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      rd(A_STAT, v);
      if (v[5:4] == 2'd1) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    int c0v [4] = '{0, 1, 2, 5};
    int c1v [3] = '{0, 1, 3};

    // R1 reset state
    do_reset();
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_FLAG, v);  chk("R1 flags", v, 0);
    rd(A_STAT, v);  chk("R1 status", v, 0);
    rd(A_CNT0, v);  chk("R1 cnt0", v, 0);
    rd(A_BASE1, v); chk("R1 base1", v, 0);
    chk("R1 quiet", {29'd0, irq, mem_req, per_ack}, 0);

    // R2 register map
    wr(A_CTRL, 32'hFFFF_FFEF); rd(A_CTRL, v); chk("R2 ctrl mask", v, 32'h4B);
    wr(A_PORT, 32'h3C);        rd(A_PORT, v); chk("R2 port", v, 32'hC);
    chk("R2 port_sel pin", 32'(port_sel), 32'hC);
    wr(A_BASE0, 32'hDEAD_BEEF); rd(A_BASE0, v); chk("R2 base0", v, 32'hDEAD_BEEF);
    wr(A_CNT1, 32'h0001_2345);  rd(A_CNT1, v);  chk("R2 cnt1", v, 32'h2345);
    rd(A_STAT, v); chk("R3 no start while disabled", v, 0);

    // R3/R6/R11 next state, hand-over and flag clear
    do_reset();
    per_req = 1'b0;
    wr(A_CTRL, 32'h12);
    wr(A_BASE0, 32'h100); wr(A_CNT0, 10);
    wr(A_BASE1, 32'h300); wr(A_CNT1, 4);
    rd(A_STAT, v); chk("R3 next state", v[5:4], 3);
    repeat (20) @(negedge clk);
    chk("R11 no byte without request", 32'(ncap), 0);
    per_req = 1'b1;
    for (int i = 0; i < 200; i++) begin
      rd(A_FLAG, v);
      if (v[1]) break;
    end
    chk("R6 switch after slot0", 32'(ncap), 10);
    rd(A_STAT, v); chk("R6 on after switch", v[5:4], 2);
    chk("R10 irq on next-buffer", 32'(irq), 1);
    wr(A_BASE0, 32'h180); wr(A_CNT0, 2);
    rd(A_FLAG, v); chk("R6 flag cleared by count write", 32'(v[1]), 0);
    rd(A_STAT, v); chk("R3 next again", v[5:4], 3);
    wait_stall();
    add_exp(32'h100, 10); add_exp(32'h300, 4); add_exp(32'h180, 2);
    chk_stream("R4 R6 ping-pong stream");

    // R4/R5/R8/R10 sweep over slot counts
    foreach (c0v[a]) begin
      foreach (c1v[b]) begin
        do_reset();
        wr(A_CTRL, 32'h10);
        wr(A_BASE0, 32'h200); wr(A_CNT0, 32'(c0v[a]));
        wr(A_BASE1, 32'h3F0); wr(A_CNT1, 32'(c1v[b]));
        wait_stall();
        add_exp(32'h200, c0v[a]); add_exp(32'h3F0, c1v[b]);
        chk_stream("R4 sweep stream");
        rd(A_FLAG, v); chk("R5 stall flag", 32'(v[0]), 1);
        chk("R10 masked stall", 32'(irq), 0);
        wr(A_CTRL, 32'h11);
        chk("R10 enabled stall", 32'(irq), 1);
        wr(A_CTRL, 32'h01);
        rd(A_STAT, v); chk("R8 stall to idle", v[5:4], 0);
      end
    end

    // R7 slot preference after a restart
    do_reset();
    wr(A_CTRL, 32'h10);
    wr(A_BASE0, 32'h40); wr(A_CNT0, 2);
    wait_stall();
    wr(A_CTRL, 32'h00);
    wr(A_BASE1, 32'h80); wr(A_CNT1, 3);
    wr(A_BASE0, 32'h20); wr(A_CNT0, 1);
    rd(A_STAT, v); chk("R3 loaded but disabled stays idle", v[5:4], 0);
    wr(A_CTRL, 32'h10);
    wait_stall();
    add_exp(32'h40, 2); add_exp(32'h80, 3); add_exp(32'h20, 1);
    chk_stream("R7 preferred slot order");

    // R8 enable drop while running
    do_reset();
    wr(A_CTRL, 32'h10);
    wr(A_BASE0, 32'h500); wr(A_CNT0, 20);
    wr(A_BASE1, 32'h700); wr(A_CNT1, 3);
    for (int i = 0; i < 200 && ncap < 5; i++) @(negedge clk);
    wr(A_CTRL, 32'h00);
    repeat (5) @(negedge clk);
    rd(A_STAT, v); chk("R8 running to idle", v[5:4], 0);
    n = ncap;
    repeat (20) @(negedge clk);
    chk("R8 no bytes after stop", 32'(ncap), 32'(n));
    wr(A_CTRL, 32'h10);
    repeat (5) @(negedge clk);
    rd(A_STAT, v); chk("R8 loaded marks dropped", v[5:4], 0);
    add_exp(32'h500, n);
    chk_stream("R8 prefix stream");

    // R9 error halts until cleared
    do_reset();
    err_idx = 2;
    wr(A_CTRL, 32'h18);
    wr(A_BASE0, 32'h600); wr(A_CNT0, 6);
    repeat (40) @(negedge clk);
    chk("R9 halted after faulty byte", 32'(ncap), 3);
    rd(A_FLAG, v); chk("R9 error flag", 32'(v[3]), 1);
    chk("R10 irq on error", 32'(irq), 1);
    rd(A_STAT, v); chk("R9 still on", v[5:4], 2);
    wr(A_FLAG, 32'h0);
    rd(A_FLAG, v); chk("R9 error cleared", 32'(v[3]), 0);
    wait_stall();
    add_exp(32'h600, 6);
    chk_stream("R9 resumed stream");

    // R9 error ignored
    do_reset();
    err_idx = 1;
    wr(A_CTRL, 32'h58);
    wr(A_BASE0, 32'h640); wr(A_CNT0, 4);
    wait_stall();
    add_exp(32'h640, 4);
    chk_stream("R9 ignore stream");
    rd(A_FLAG, v); chk("R9 error flag with ignore", 32'(v[3]), 1);
    chk("R10 irq with ignore", 32'(irq), 1);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule